// File: doc/BRIEF.md
# Replication Enable Controller for Timing Speculation

This block sits beside one functional unit and decides when that unit's shadow pipeline registers are powered and clocking. When they are on, the main register and the late-clocked shadow register capture the same result and can be compared. The shadow combinational logic stays off. The only output that drives the shadow side is one enable. The controller also holds the unit's supply rail select, which is an index into a small set of two or three rails.

Normal control comes from a replica critical path that is longer than the unit's real worst path. The replica raises a warning before real timing errors begin. The warning is synchronised and turns replication on at once. Replication turns off only after the warning has been quiet for several cycles in a row, which stops the enable from toggling. A write that lowers the rail select forces replication on immediately and holds it on for a programmable window. Every further lowering restarts that window. When the window runs out, the sensor is back in control. A write that raises the rail does not force anything.

Top module: `repl_ctrl`

## Requirements
- R1: After reset, `repl_en_o` is 0 and `rail_sel_o` equals NUM_RAILS-1, the highest supply (a larger index means a higher voltage).
- R2: A write with `lvl_wr_i`=1 and a legal `lvl_i` below the current `rail_sel_o` sets `repl_en_o` to 1 at the same clock edge that captures the write.
- R3: After a lowering write, `repl_en_o` stays 1 for the hold window. The window is `cfg_hold_i` cycles, or 8 cycles when `cfg_hold_i` is 0. Once the window has expired and the sensor is quiet, `repl_en_o` returns to 0.
- R4: A further lowering write during the hold window restarts the window from its full length.
- R5: A write with `lvl_i` >= NUM_RAILS (with the defaults, value 3) is ignored: `rail_sel_o` keeps its value and replication is not forced.
- R6: A write that raises the level, or that writes the same level, updates `rail_sel_o` where that applies but does not force `repl_en_o` on.
- R7: `sensor_i` passes through a two-flop synchroniser. A rise on `sensor_i` sets `repl_en_o` to 1 within 3 clock edges.
- R8: `repl_en_o` falls only after the synchronised sensor has been quiet for 4 consecutive cycles. A quiet gap shorter than that leaves `repl_en_o` at 1.
- R9: A legal write loads `lvl_i` into `rail_sel_o` at the clock edge that captures it, and `rail_sel_o` always stays below NUM_RAILS.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sensor_i | input | 1 | Replica-path warning, asynchronous |
| lvl_wr_i | input | 1 | Rail select write strobe |
| lvl_i | input | LVL_W (2) | Requested rail index |
| cfg_hold_i | input | HOLD_W (4) | Hold window length, 0 selects the default |
| repl_en_o | output | 1 | Shadow register enable |
| rail_sel_o | output | LVL_W (2) | Current rail index |

## Verification
Some properties are checked on every cycle. A lowering write always turns on the enable at the next edge, and a legal write always loads the rail. An illegal write never changes the rail, and the rail never leaves its legal range. The enable never falls while the hold window or the synchronised warning is active. Other behaviour shows only in the bench's directed scenarios: the exact length of the hold window, its restart, the default that 0 selects, the 4-cycle quiet filter rejecting a short gap, and the fact that raising the rail does not force replication.

// File: rtl/repl_ctrl_pkg.sv
package repl_ctrl_pkg;
  typedef enum logic [1:0] {
    LV_NONE = 2'd0,
    LV_DOWN = 2'd1,
    LV_UP   = 2'd2,
    LV_SAME = 2'd3
  } lvl_evt_e;
endpackage

// File: rtl/repl_sync.sv
module repl_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sr_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sr_q <= '0;
    else         sr_q <= {sr_q[STAGES-2:0], d_i};
  end
  assign q_o = sr_q[STAGES-1];
endmodule

// File: rtl/repl_rail_reg.sv
module repl_rail_reg
  import repl_ctrl_pkg::*;
#(
  parameter int NUM_RAILS = 3,
  localparam int LVL_W = $clog2(NUM_RAILS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [LVL_W-1:0] lvl_i,
  output logic [LVL_W-1:0] rail_o,
  output lvl_evt_e         evt_o
);
  localparam logic [LVL_W-1:0] MAX_LVL = LVL_W'(NUM_RAILS - 1);

  logic legal;
  assign legal = wr_i && (lvl_i <= MAX_LVL);

  always_comb begin
    if (!legal)              evt_o = LV_NONE;
    else if (lvl_i < rail_o) evt_o = LV_DOWN;
    else if (lvl_i > rail_o) evt_o = LV_UP;
    else                     evt_o = LV_SAME;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    rail_o <= MAX_LVL;
    else if (legal) rail_o <= lvl_i;
  end
endmodule

// File: rtl/repl_hold_timer.sv
module repl_hold_timer #(
  parameter int HOLD_W   = 4,
  parameter int HOLD_DEF = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [HOLD_W-1:0] len_i,
  output logic              busy_o
);
  logic [HOLD_W-1:0] cnt_q, load_len;
  assign load_len = (len_i == '0) ? HOLD_W'(HOLD_DEF) : len_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (start_i)       cnt_q <= load_len;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end
  assign busy_o = (cnt_q != '0);
endmodule

// File: rtl/repl_quiet_filt.sv
module repl_quiet_filt #(
  parameter int QUIET = 4,
  localparam int QW = $clog2(QUIET + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic warn_i,
  output logic quiet_o
);
  logic [QW-1:0] cnt_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   cnt_q <= '0;
    else if (warn_i)               cnt_q <= '0;
    else if (cnt_q != QW'(QUIET))  cnt_q <= cnt_q + 1'b1;
  end
  assign quiet_o = (cnt_q == QW'(QUIET)) && !warn_i;
endmodule

// File: rtl/repl_ctrl.sv
module repl_ctrl
  import repl_ctrl_pkg::*;
#(
  parameter int NUM_RAILS = 3,
  parameter int HOLD_W    = 4,
  parameter int HOLD_DEF  = 8,
  parameter int QUIET     = 4,
  localparam int LVL_W = $clog2(NUM_RAILS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sensor_i,
  input  logic              lvl_wr_i,
  input  logic [LVL_W-1:0]  lvl_i,
  input  logic [HOLD_W-1:0] cfg_hold_i,
  output logic              repl_en_o,
  output logic [LVL_W-1:0]  rail_sel_o
);
  logic     warn_s, hold_busy, quiet;
  lvl_evt_e evt;

  repl_sync #(.STAGES(2)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(sensor_i), .q_o(warn_s)
  );

  repl_rail_reg #(.NUM_RAILS(NUM_RAILS)) u_rail (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_i(lvl_wr_i), .lvl_i(lvl_i),
    .rail_o(rail_sel_o), .evt_o(evt)
  );

  repl_hold_timer #(.HOLD_W(HOLD_W), .HOLD_DEF(HOLD_DEF)) u_hold (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(evt == LV_DOWN),
    .len_i(cfg_hold_i), .busy_o(hold_busy)
  );

  repl_quiet_filt #(.QUIET(QUIET)) u_quiet (
    .clk_i(clk_i), .rst_ni(rst_ni), .warn_i(warn_s), .quiet_o(quiet)
  );

  // Forced on by a lowering or the hold window; off only after a quiet run
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                  repl_en_o <= 1'b0;
    else if (evt == LV_DOWN || hold_busy || warn_s) repl_en_o <= 1'b1;
    else if (quiet)                               repl_en_o <= 1'b0;
  end
endmodule

// File: rtl/repl_ctrl_chk.sv
module repl_ctrl_chk #(
  parameter int NUM_RAILS = 3,
  parameter int LVL_W = 2
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             lvl_wr_i,
  input logic [LVL_W-1:0] lvl_i,
  input logic             repl_en_o,
  input logic [LVL_W-1:0] rail_sel_o,
  input logic             warn_s,
  input logic             hold_busy
);
  a_r2_down_forces_en: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lvl_wr_i && int'(lvl_i) < NUM_RAILS && lvl_i < rail_sel_o) |=> repl_en_o);

  a_r5_illegal_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lvl_wr_i && int'(lvl_i) >= NUM_RAILS) |=> $stable(rail_sel_o));

  a_r9_rail_loads: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lvl_wr_i && int'(lvl_i) < NUM_RAILS) |=> rail_sel_o == $past(lvl_i));

  a_r9_rail_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(rail_sel_o) < NUM_RAILS);

  a_r3_no_fall_in_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(repl_en_o) |-> !$past(hold_busy));

  a_r8_no_fall_on_warn: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(repl_en_o) |-> !$past(warn_s));
endmodule

bind repl_ctrl repl_ctrl_chk #(.NUM_RAILS(NUM_RAILS), .LVL_W(LVL_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .lvl_wr_i(lvl_wr_i), .lvl_i(lvl_i),
  .repl_en_o(repl_en_o), .rail_sel_o(rail_sel_o),
  .warn_s(warn_s), .hold_busy(hold_busy)
);

// File: tb/sim_repl_ctrl.sv
`timescale 1ns/1ps
module sim_repl_ctrl;
  logic       clk = 1'b0, rst_ni = 1'b0;
  logic       sensor_i = 1'b0, lvl_wr_i = 1'b0;
  logic [1:0] lvl_i = '0;
  logic [3:0] cfg_hold_i = '0;
  logic       repl_en_o;
  logic [1:0] rail_sel_o;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  repl_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_ni), .sensor_i(sensor_i), .lvl_wr_i(lvl_wr_i),
    .lvl_i(lvl_i), .cfg_hold_i(cfg_hold_i), .repl_en_o(repl_en_o),
    .rail_sel_o(rail_sel_o)
  );

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  // returns just after the capturing edge
  task automatic wr_lvl(logic [1:0] v);
    lvl_wr_i = 1'b1; lvl_i = v;
    tick(1);
    lvl_wr_i = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 en", repl_en_o, 0);
    chk("R1 rail", rail_sel_o, 2);
  endtask

  task automatic t_default_hold();
    cfg_hold_i = 4'd0;
    wr_lvl(2'd1);
    chk("R2 forced", repl_en_o, 1);
    chk("R9 rail", rail_sel_o, 1);
    tick(7);
    chk("R3 held at 8", repl_en_o, 1);
    tick(4);
    chk("R3 released", repl_en_o, 0);
  endtask

  task automatic t_prog_hold();
    cfg_hold_i = 4'd3;
    wr_lvl(2'd2);
    chk("R6 raise no force", repl_en_o, 0);
    tick(3);
    chk("R6 raise stays off", repl_en_o, 0);
    wr_lvl(2'd0);
    chk("R2 forced", repl_en_o, 1);
    tick(2);
    chk("R3 short hold", repl_en_o, 1);
    tick(3);
    chk("R3 short release", repl_en_o, 0);
    cfg_hold_i = 4'd0;
    wr_lvl(2'd2);
  endtask

  task automatic t_restart();
    cfg_hold_i = 4'd0;
    wr_lvl(2'd1);
    tick(4);
    wr_lvl(2'd0);
    tick(7);
    chk("R4 restarted", repl_en_o, 1);
    tick(4);
    chk("R4 end", repl_en_o, 0);
  endtask

  task automatic t_illegal_same();
    wr_lvl(2'd3);
    chk("R5 rail kept", rail_sel_o, 0);
    tick(1);
    chk("R5 no force", repl_en_o, 0);
    wr_lvl(2'd0);
    tick(1);
    chk("R6 same no force", repl_en_o, 0);
    wr_lvl(2'd2);
    chk("R9 rail up", rail_sel_o, 2);
    wr_lvl(2'd3);
    chk("R5 rail kept hi", rail_sel_o, 2);
  endtask

  task automatic t_sensor();
    sensor_i = 1'b1;
    tick(1);
    chk("R7 sync delay", repl_en_o, 0);
    tick(2);
    chk("R7 sensor on", repl_en_o, 1);
    tick(3);
    sensor_i = 1'b0;
    tick(2);
    sensor_i = 1'b1;
    tick(1);
    sensor_i = 1'b0;
    tick(4);
    chk("R8 gap filtered", repl_en_o, 1);
    tick(6);
    chk("R8 off after quiet", repl_en_o, 0);
  endtask

  task automatic t_quiet_len();
    sensor_i = 1'b1;
    tick(4);
    sensor_i = 1'b0;
    tick(5);
    chk("R8 held during quiet", repl_en_o, 1);
    tick(3);
    chk("R8 released", repl_en_o, 0);
  endtask

  initial begin
    tick(2);
    t_reset();
    rst_ni = 1'b1;
    tick(2);
    t_reset();
    t_default_hold();
    t_prog_hold();
    t_restart();
    t_illegal_same();
    t_sensor();
    t_quiet_len();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual 0 expected 1 (done)");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule